// File: doc/BRIEF.md
# Three-Level Interrupt Aggregator with Byte Register Access

This block collects a large set of interrupt input lines, groups them into blocks of eight lines, groups the blocks into masters of eight blocks, and reports the result as a three-level summary tree (root, master, block). A single interrupt output is high whenever any line holds a pending event. Software walks the tree from the root down to find which lines fired.

Each line has its own trigger setting: edge or level sensing, with separate mask bits for the rising and falling sense. Configuration and per-block status are reached indirectly. Software first writes a block number into a select register. It then either reads that block's pending or live-level byte, or writes a configuration byte. The configuration byte itself names the line inside the block, carries a commit flag and can request a clear of that line's pending bit. Every input passes through a two-flop synchroniser before detection. Register access is a plain byte-wide bus with a write strobe and a combinational read port.

Top module: `irq_tree_regs`

## Requirements
- R1: After reset every pending bit is 0, `irq_out` is 0, the select register holds 0, and every line is in edge mode with both mask bits set, so input toggles set nothing until a line is configured.
- R2: Register offsets: 0 root, 1 to 4 master status for masters 0 to 3, 5 block select (written with the block number, reads back the same value), 6 pending byte of the selected block, 7 configuration (write only), 8 synchronised level of the selected block. Every other offset, and offset 7, reads as 0.
- R3: Line number = block×8 + bit and block number = master×8 + bit. Offset 6 returns in bit b the pending state of line (selected block)×8 + b.
- R4: In the root byte, bit m+1 is 1 exactly when master m has any pending line. Bit 0 always reads 0.
- R5: In master m's byte, bit b is 1 exactly when block m×8 + b has any pending line.
- R6: Configuration byte: bit 0 level mode, bit 1 falling mask, bit 2 rising mask, bit 3 clear request, bits 6:4 line within the selected block, bit 7 commit. A write with bit 7 at 0 changes neither pending state nor trigger settings.
- R7: In edge mode, a 0 in the rising mask enables rising-edge detection and a 0 in the falling mask enables falling-edge detection; both at 0 detects both edges. A detected edge sets the pending bit, which then holds until cleared, whatever the input does.
- R8: In level mode, a 0 in the rising mask makes a high input set pending, a 0 in the falling mask makes a low input set pending, and both mask bits at 1 mask the line fully.
- R9: A committed write with bit 3 set clears the addressed line's pending bit on the same edge that loads its new trigger settings. A level-mode line whose input is still active is pending again one cycle later.
- R10: An input change shows in the level byte (offset 8) after two rising clock edges, and a resulting pending bit appears after the third.
- R11: `irq_out` is the OR of all pending bits. It falls on the edge that clears the last pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_MASTERS*64 | Asynchronous interrupt inputs, one per line |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | High while any line is pending |

## Verification
The bench builds the block with its default of four masters, so all 256 lines exist. This makes the last master slot (offset 4), the top block number 31 and line 255 reachable, along with the lowest line 0. Lines in different masters pend at the same time, so the root and master bytes are checked with bits set at both ends of each byte. Each trigger variant is driven through the exact synchroniser latency, and the same-edge clear is checked against a level input that stays active.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
  localparam int LINES_PER_BLOCK   = 8;
  localparam int BLOCKS_PER_MASTER = 8;
  localparam int MAX_MASTERS       = 4;

  localparam logic [3:0] OFF_ROOT    = 4'd0;
  localparam logic [3:0] OFF_MASTER0 = 4'd1;
  localparam logic [3:0] OFF_BLKSEL  = 4'd5;
  localparam logic [3:0] OFF_BLKSTAT = 4'd6;
  localparam logic [3:0] OFF_CFG     = 4'd7;
  localparam logic [3:0] OFF_LEVEL   = 4'd8;

  localparam int CB_LEVEL  = 0;
  localparam int CB_NOFALL = 1;
  localparam int CB_NORISE = 2;
  localparam int CB_CLEAR  = 3;
  localparam int CB_LINE   = 4;
  localparam int CB_COMMIT = 7;

  typedef struct packed {
    logic level_mode;
    logic no_fall;
    logic no_rise;
  } trig_cfg_t;

  localparam trig_cfg_t TRIG_RESET = '{level_mode: 1'b0, no_fall: 1'b1, no_rise: 1'b1};
endpackage

// File: rtl/irq_line_cell.sv
module irq_line_cell
  import irq_tree_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      raw_in,
  input  logic      cfg_wr,
  input  trig_cfg_t cfg_new,
  input  logic      clr_req,
  output logic      pending,
  output logic      level_sync
);
  logic [2:0] shreg;
  trig_cfg_t  cfg_q;
  logic       rise, fall, lvl_hit, edge_hit, hit;

  always_ff @(posedge clk) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[1:0], raw_in};
  end

  assign level_sync = shreg[1];
  assign rise       = shreg[1] & ~shreg[2];
  assign fall       = ~shreg[1] & shreg[2];

  always_comb begin
    lvl_hit  = (~cfg_q.no_rise & shreg[1]) | (~cfg_q.no_fall & ~shreg[1]);
    edge_hit = (~cfg_q.no_rise & rise) | (~cfg_q.no_fall & fall);
    hit      = cfg_q.level_mode ? lvl_hit : edge_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= TRIG_RESET;
    else if (cfg_wr) cfg_q <= cfg_new;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 pending <= 1'b0;
    else if (cfg_wr && clr_req) pending <= 1'b0;
    else if (hit)               pending <= 1'b1;
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_tree_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  localparam int NUM_BLOCKS = NUM_MASTERS * BLOCKS_PER_MASTER,
  localparam int NUM_LINES  = NUM_BLOCKS * LINES_PER_BLOCK
) (
  input  logic [NUM_LINES-1:0]       pend,
  output logic [MAX_MASTERS*8-1:0]   master_flat,
  output logic [7:0]                 root_stat,
  output logic                       irq_any
);
  for (genvar m = 0; m < MAX_MASTERS; m++) begin : g_master
    if (m < NUM_MASTERS) begin : g_live
      for (genvar b = 0; b < BLOCKS_PER_MASTER; b++) begin : g_blk
        localparam int BLK = m * BLOCKS_PER_MASTER + b;
        assign master_flat[m*8+b] = |pend[BLK*LINES_PER_BLOCK +: LINES_PER_BLOCK];
      end
    end else begin : g_absent
      assign master_flat[m*8 +: 8] = '0;
    end
    assign root_stat[m+1] = |master_flat[m*8 +: 8];
  end

  assign root_stat[0] = 1'b0;
  assign root_stat[7:MAX_MASTERS+1] = '0;
  assign irq_any = |root_stat;
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_tree_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  localparam int NUM_BLOCKS = NUM_MASTERS * BLOCKS_PER_MASTER,
  localparam int NUM_LINES  = NUM_BLOCKS * LINES_PER_BLOCK,
  localparam int BLK_W      = $clog2(NUM_BLOCKS),
  localparam int LINE_W     = BLK_W + 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [3:0]               bus_addr,
  input  logic                     bus_wr,
  input  logic [7:0]               bus_wdata,
  input  logic [NUM_LINES-1:0]     pend,
  input  logic [NUM_LINES-1:0]     levels,
  input  logic [MAX_MASTERS*8-1:0] master_flat,
  input  logic [7:0]               root_stat,
  output logic [7:0]               bus_rdata,
  output logic [BLK_W-1:0]         blk_sel,
  output logic                     cfg_wr,
  output logic [LINE_W-1:0]        cfg_line,
  output trig_cfg_t                cfg_new,
  output logic                     cfg_clr
);
  logic       sel_valid;
  logic [7:0] sel_pend, sel_level;

  always_ff @(posedge clk) begin
    if (!rst_n)                               blk_sel <= '0;
    else if (bus_wr && bus_addr == OFF_BLKSEL) blk_sel <= bus_wdata[BLK_W-1:0];
  end

  assign sel_valid = (32'(blk_sel) < NUM_BLOCKS);
  assign cfg_wr    = bus_wr && (bus_addr == OFF_CFG) && bus_wdata[CB_COMMIT] && sel_valid;
  assign cfg_line  = {blk_sel, bus_wdata[CB_LINE +: 3]};
  assign cfg_clr   = bus_wdata[CB_CLEAR];
  assign cfg_new   = '{level_mode: bus_wdata[CB_LEVEL],
                       no_fall:    bus_wdata[CB_NOFALL],
                       no_rise:    bus_wdata[CB_NORISE]};

  always_comb begin
    sel_pend  = '0;
    sel_level = '0;
    for (int b = 0; b < NUM_BLOCKS; b++) begin
      if (blk_sel == BLK_W'(b)) begin
        sel_pend  = pend[b*LINES_PER_BLOCK +: LINES_PER_BLOCK];
        sel_level = levels[b*LINES_PER_BLOCK +: LINES_PER_BLOCK];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFF_ROOT:    bus_rdata = root_stat;
      OFF_BLKSEL:  bus_rdata = 8'(blk_sel);
      OFF_BLKSTAT: bus_rdata = sel_pend;
      OFF_LEVEL:   bus_rdata = sel_level;
      default: begin
        for (int m = 0; m < MAX_MASTERS; m++)
          if (bus_addr == OFF_MASTER0 + 4'(m)) bus_rdata = master_flat[m*8 +: 8];
      end
    endcase
  end
endmodule

// File: rtl/irq_tree_regs.sv
module irq_tree_regs
  import irq_tree_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  localparam int NUM_BLOCKS = NUM_MASTERS * BLOCKS_PER_MASTER,
  localparam int NUM_LINES  = NUM_BLOCKS * LINES_PER_BLOCK,
  localparam int BLK_W      = $clog2(NUM_BLOCKS),
  localparam int LINE_W     = BLK_W + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic [3:0]           bus_addr,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  output logic                 irq_out
);
  logic [NUM_LINES-1:0]     pend_vec, level_vec;
  logic [MAX_MASTERS*8-1:0] master_flat;
  logic [7:0]               root_stat;
  logic [BLK_W-1:0]         blk_sel;
  logic                     cfg_wr, cfg_clr;
  logic [LINE_W-1:0]        cfg_line;
  trig_cfg_t                cfg_new;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    irq_line_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_in    (irq_lines[i]),
      .cfg_wr    (cfg_wr && (cfg_line == LINE_W'(i))),
      .cfg_new   (cfg_new),
      .clr_req   (cfg_clr),
      .pending   (pend_vec[i]),
      .level_sync(level_vec[i])
    );
  end

  irq_summary #(.NUM_MASTERS(NUM_MASTERS)) u_sum (
    .pend       (pend_vec),
    .master_flat(master_flat),
    .root_stat  (root_stat),
    .irq_any    (irq_out)
  );

  irq_reg_decode #(.NUM_MASTERS(NUM_MASTERS)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .pend       (pend_vec),
    .levels     (level_vec),
    .master_flat(master_flat),
    .root_stat  (root_stat),
    .bus_rdata  (bus_rdata),
    .blk_sel    (blk_sel),
    .cfg_wr     (cfg_wr),
    .cfg_line   (cfg_line),
    .cfg_new    (cfg_new),
    .cfg_clr    (cfg_clr)
  );
endmodule

// File: rtl/irq_tree_regs_chk.sv
module irq_tree_regs_chk
  import irq_tree_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  localparam int NUM_BLOCKS = NUM_MASTERS * BLOCKS_PER_MASTER,
  localparam int NUM_LINES  = NUM_BLOCKS * LINES_PER_BLOCK,
  localparam int BLK_W      = $clog2(NUM_BLOCKS),
  localparam int LINE_W     = BLK_W + 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [3:0]           bus_addr,
  input logic                 bus_wr,
  input logic [7:0]           bus_wdata,
  input logic [7:0]           bus_rdata,
  input logic                 irq_out,
  input logic [NUM_LINES-1:0] pend_vec,
  input logic [BLK_W-1:0]     blk_sel
);
  logic              clr_seen;
  logic [LINE_W-1:0] clr_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_seen <= 1'b0;
      clr_idx  <= '0;
    end else begin
      clr_seen <= bus_wr && (bus_addr == OFF_CFG) && bus_wdata[CB_COMMIT] &&
                  bus_wdata[CB_CLEAR] && (32'(blk_sel) < NUM_BLOCKS);
      clr_idx  <= {blk_sel, bus_wdata[CB_LINE +: 3]};
    end
  end

  // R4: root bit 0 never reports a master
  p_root_bit0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_ROOT) |-> !bus_rdata[0]);

  // R4: with no interrupt, the root reads all zero
  p_root_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_ROOT && !irq_out) |-> (bus_rdata == 8'h00));

  // R11: output equals OR of pending latches
  p_irq_or_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (|pend_vec));

  // R9: a committed clear empties the addressed line on that edge
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_seen |-> !pend_vec[clr_idx]);

  // R2: select register only changes through its own offset
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFF_BLKSEL) |=> $stable(blk_sel));
endmodule

bind irq_tree_regs irq_tree_regs_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .irq_out  (irq_out),
  .pend_vec (pend_vec),
  .blk_sel  (blk_sel)
);

// File: tb/tb_irq_tree_regs.sv
module tb_irq_tree_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 4;
  localparam int NL = NM * 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq_lines = '0;
  logic [3:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          irq_out;
  int            n_run = 0, n_fail = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_tree_regs #(.NUM_MASTERS(NM)) dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // config byte: commit, line, clear, rising mask, falling mask, level mode
  task automatic cfg(input int line, input bit clr, input bit norise, input bit nofall, input bit lvl);
    wr(4'd5, 8'(line / 8));
    wr(4'd7, {1'b1, 3'(line % 8), clr, norise, nofall, lvl});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(4'd0, d); chk("R1 root after reset", d, 8'h00);
    chk("R1 irq after reset", 8'(irq_out), 8'h00);
    rd(4'd5, d); chk("R1 select after reset", d, 8'h00);
    irq_lines[5] = 1'b1; wait_n(5);
    irq_lines[5] = 1'b0; wait_n(5);
    rd(4'd6, d); chk("R1 masked line stays clear", d, 8'h00);
    chk("R1 irq stays low", 8'(irq_out), 8'h00);
    rd(4'd12, d); chk("R2 unused offset reads 0", d, 8'h00);
  endtask

  task automatic t_edge_rise();
    logic [7:0] d;
    cfg(77, 1, 0, 1, 0);
    irq_lines[77] = 1'b1;
    wait_n(2);
    chk("R10 no pend after two edges", 8'(irq_out), 8'h00);
    rd(4'd8, d); chk("R10 level byte after two edges", d, 8'h20);
    wait_n(1);
    chk("R10 pend after third edge", 8'(irq_out), 8'h01);
    rd(4'd6, d); chk("R3 block 9 pending byte", d, 8'h20);
    rd(4'd2, d); chk("R5 master 1 byte", d, 8'h02);
    rd(4'd0, d); chk("R4 root for master 1", d, 8'h04);
    rd(4'd7, d); chk("R2 config offset reads 0", d, 8'h00);
    irq_lines[77] = 1'b0; wait_n(4);
    chk("R7 edge pending held", 8'(irq_out), 8'h01);
    cfg(77, 1, 0, 1, 0);
    chk("R9 edge clear", 8'(irq_out), 8'h00);
  endtask

  task automatic t_edge_fall();
    logic [7:0] d;
    cfg(200, 1, 1, 0, 0);
    irq_lines[200] = 1'b1; wait_n(5);
    chk("R7 falling-only ignores rise", 8'(irq_out), 8'h00);
    irq_lines[200] = 1'b0; wait_n(2);
    chk("R10 fall not yet pending", 8'(irq_out), 8'h00);
    wait_n(1);
    chk("R7 fall detected", 8'(irq_out), 8'h01);
    rd(4'd4, d); chk("R5 master 3 byte", d, 8'h02);
    rd(4'd0, d); chk("R4 root for master 3", d, 8'h10);
    rd(4'd6, d); chk("R3 block 25 pending byte", d, 8'h01);
    cfg(200, 1, 1, 1, 0);
    chk("R11 irq drops after clear", 8'(irq_out), 8'h00);
  endtask

  task automatic t_both_edges();
    cfg(0, 1, 0, 0, 0);
    irq_lines[0] = 1'b1; wait_n(3);
    chk("R7 both edges rise", 8'(irq_out), 8'h01);
    cfg(0, 1, 0, 0, 0);
    chk("R9 clear both-edge line", 8'(irq_out), 8'h00);
    irq_lines[0] = 1'b0; wait_n(3);
    chk("R7 both edges fall", 8'(irq_out), 8'h01);
    cfg(0, 1, 1, 1, 0);
  endtask

  task automatic t_commit();
    cfg(3, 1, 0, 1, 0);
    irq_lines[3] = 1'b1; wait_n(3);
    chk("R6 line 3 pending", 8'(irq_out), 8'h01);
    wr(4'd7, {1'b0, 3'd3, 1'b1, 1'b1, 1'b1, 1'b0});
    wait_n(2);
    chk("R6 uncommitted clear ignored", 8'(irq_out), 8'h01);
    cfg(3, 1, 1, 1, 0);
    chk("R6 committed clear", 8'(irq_out), 8'h00);
    irq_lines[3] = 1'b0;
    wr(4'd7, {1'b0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0});
    irq_lines[4] = 1'b1; wait_n(4);
    irq_lines[4] = 1'b0; wait_n(4);
    chk("R6 uncommitted unmask ignored", 8'(irq_out), 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] d;
    cfg(130, 1, 0, 1, 1);
    irq_lines[130] = 1'b1; wait_n(3);
    rd(4'd6, d); chk("R8 active-high pending", d, 8'h04);
    wr(4'd7, {1'b1, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1});
    rd(4'd6, d); chk("R9 same-edge clear", d, 8'h00);
    wait_n(1);
    rd(4'd6, d); chk("R9 level re-pends next cycle", d, 8'h04);
    irq_lines[130] = 1'b0; wait_n(3);
    wr(4'd7, {1'b1, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1});
    wait_n(4);
    rd(4'd6, d); chk("R8 inactive high stays clear", d, 8'h00);
    wr(4'd7, {1'b1, 3'd2, 1'b1, 1'b1, 1'b0, 1'b1});
    wait_n(1);
    rd(4'd6, d); chk("R8 active-low pending", d, 8'h04);
    irq_lines[130] = 1'b1; wait_n(3);
    wr(4'd7, {1'b1, 3'd2, 1'b1, 1'b1, 1'b0, 1'b1});
    wait_n(3);
    rd(4'd6, d); chk("R8 active-low released", d, 8'h00);
    wr(4'd7, {1'b1, 3'd2, 1'b1, 1'b1, 1'b1, 1'b1});
    irq_lines[130] = 1'b0; wait_n(4);
    rd(4'd6, d); chk("R8 fully masked low", d, 8'h00);
    irq_lines[130] = 1'b1; wait_n(4);
    rd(4'd6, d); chk("R8 fully masked high", d, 8'h00);
    irq_lines[130] = 1'b0;
  endtask

  task automatic t_multi();
    logic [7:0] d;
    cfg(0, 1, 0, 1, 0);
    cfg(255, 1, 0, 1, 0);
    irq_lines[0] = 1'b1; irq_lines[255] = 1'b1;
    wait_n(3);
    rd(4'd0, d); chk("R4 root two masters", d, 8'h12);
    rd(4'd1, d); chk("R5 master 0 byte", d, 8'h01);
    rd(4'd4, d); chk("R5 master 3 top block", d, 8'h80);
    rd(4'd5, d); chk("R2 select readback", d, 8'd31);
    rd(4'd6, d); chk("R3 line 255 in block 31", d, 8'h80);
    cfg(0, 1, 1, 1, 0);
    chk("R11 irq held by other line", 8'(irq_out), 8'h01);
    cfg(255, 1, 1, 1, 0);
    chk("R11 irq drops at last clear", 8'(irq_out), 8'h00);
    irq_lines[0] = 1'b0; irq_lines[255] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_edge_rise();
    t_edge_fall();
    t_both_edges();
    t_commit();
    t_level();
    t_multi();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule